// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits between the host write port of a flash memory and its embedded operation engine. Every host write presents an address and a data word on a one-cycle strobe. The sequencer follows the write sequence cycle by cycle. It first checks a two-write unlock pattern at fixed addresses, then decodes the command byte and tracks any further cycles the command needs. When a sequence completes, it emits a single-cycle operation pulse that carries an operation code plus the address and data of the final write.

The sequencer keeps its own record of what the engine is doing: idle, programming, chip erase, sector erase, or an erase that is suspended. It takes this record together with a busy input from the engine, and uses both to decide whether a start, suspend, resume or configuration write may be issued. It also holds three mode flags: unlock bypass, autoselect and CFI query. Bypass mode lets later program and erase commands skip the unlock pair.

A parameter selects the word-wide address pattern or the half-word pattern, which uses shifted unlock addresses.

Top module: `flash_cmd_seq`

## Requirements
- R1: In word-wide mode the unlock pair is 0xAA written to address 0x555, then 0x55 written to 0x2AA, and the command byte is written to 0x555. Only address bits [10:0] and data bits [7:0] take part in these comparisons; all higher bits are ignored.
- R2: Unlock followed by command 0xA0 makes the next write a program cycle. One cycle after that write, op_valid is high for one cycle with op_kind = 1 and with op_addr/op_data equal to the full address and data of the write. A data byte of 0xF0 in this cycle counts as program data and does not reset.
- R3: Unlock, command 0x80, a second unlock pair, then 0x10 at 0x555 pulses op_kind = 2 (chip erase). If the last write is instead 0x30 at any address, it pulses op_kind = 3 (sector erase) and op_addr carries that address.
- R4: Any write that does not match the cycle expected next returns the sequencer to idle, and no operation pulse follows.
- R5: A write whose low byte is 0xF0 at any address, outside a program or configuration data cycle, pulses op_kind = 8. It clears the autoselect and CFI flags and returns the sequencer to idle. The bypass flag is left as it is. All flags and op_valid are 0 after reset.
- R6: A single write of 0xB0 pulses op_kind = 4 (suspend) only while a sector erase is running. A single write of 0x30 pulses op_kind = 5 (resume) only while an erase is suspended. In any other state neither write produces a pulse.
- R7: Unlock plus command 0x20 sets bypass_mode. While bypass_mode is set: 0xA0 followed by a data write programs (kind 1); 0x80 followed by 0x10 starts a chip erase (kind 2); 0x98 at any address enters CFI (kind 7); the pair 0x90 then 0x00 clears bypass_mode.
- R8: Unlock plus command 0x90 pulses op_kind = 6 and sets autoselect_mode. A single write of 0x98 to address 0x55 pulses op_kind = 7 and sets cfi_mode. The same byte written to any other address has no effect.
- R9: While busy is high, or while the tracked engine state is not idle, a completed program or erase sequence produces no pulse. Reset and suspend still decode while busy is high.
- R10: Unlock, command 0xD0, then a data write pulses op_kind = 9 (configuration write) with that address and data. The command is dropped if a program, erase or suspend is active when it is decoded.
- R11: The tracked program/erase state returns to idle on the first falling edge of busy after the operation starts. After that, new starts are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Operation engine busy |
| op_valid | output | 1 | One-cycle operation pulse |
| op_kind | output | 4 | Operation code (see requirements) |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| bypass_mode | output | 1 | Unlock bypass active |
| autosel_mode | output | 1 | Autoselect mode active |
| cfi_mode | output | 1 | CFI query mode active |

## Verification
The hardest situation to reach is a suspend or resume being accepted. The only way to get there is a full six-write sector erase, followed by the engine's busy line rising and then falling while the suspend is held. The stimulus runs the complete erase sequence and then raises busy to model the engine. It then sends resume (which must be ignored while the erase runs), suspend while busy is high, a second suspend after busy drops (ignored), and finally the resume. The same busy modelling also lets the bench show that a configuration write is refused while a program has been issued but has not yet finished.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [3:0] {
      OPK_NONE         = 4'd0,
      OPK_PROGRAM      = 4'd1,
      OPK_CHIP_ERASE   = 4'd2,
      OPK_SECTOR_ERASE = 4'd3,
      OPK_SUSPEND      = 4'd4,
      OPK_RESUME       = 4'd5,
      OPK_AUTOSEL      = 4'd6,
      OPK_CFI          = 4'd7,
      OPK_RESET        = 4'd8,
      OPK_CFG_WRITE    = 4'd9
   } op_kind_t;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_RUN_PGM,
      ENG_RUN_CE,
      ENG_RUN_SE,
      ENG_SUSP
   } eng_t;

   typedef enum logic [3:0] {
      S_IDLE, S_UL1, S_UL2, S_PGM_DATA,
      S_ER_UL0, S_ER_UL1, S_ER_CMD, S_CFG_DATA,
      S_BYP_PGM, S_BYP_ER, S_BYP_EXIT
   } seq_t;

   localparam logic [7:0] B_KEY1     = 8'hAA;
   localparam logic [7:0] B_KEY2     = 8'h55;
   localparam logic [7:0] B_PROGRAM  = 8'hA0;
   localparam logic [7:0] B_ERASE    = 8'h80;
   localparam logic [7:0] B_CHIP     = 8'h10;
   localparam logic [7:0] B_SECTOR   = 8'h30;
   localparam logic [7:0] B_RESUME   = 8'h30;
   localparam logic [7:0] B_SUSPEND  = 8'hB0;
   localparam logic [7:0] B_RESET    = 8'hF0;
   localparam logic [7:0] B_BYPASS   = 8'h20;
   localparam logic [7:0] B_AUTOSEL  = 8'h90;
   localparam logic [7:0] B_BYP_OUT  = 8'h00;
   localparam logic [7:0] B_CFI      = 8'h98;
   localparam logic [7:0] B_CFG      = 8'hD0;

   function automatic int cmp_width(input bit half_word);
      return half_word ? 12 : 11;
   endfunction

endpackage

// File: rtl/fsc_cycle_match.sv
module fsc_cycle_match
   import flash_seq_pkg::*;
#(
   parameter bit HALF_WORD = 1'b0,
   localparam int CW = cmp_width(HALF_WORD)
)(
   input  logic [CW-1:0] addr_lo,
   input  logic [7:0]    data_lo,
   output logic          hit_key1,
   output logic          hit_key2,
   output logic          at_cmd,
   output logic          at_cfi
);

   logic [CW-1:0] a_key1, a_key2, a_cfi;

   generate
      if (HALF_WORD) begin : g_half
         assign a_key1 = CW'(12'hAAA);
         assign a_key2 = CW'(12'h555);
         assign a_cfi  = CW'(12'h0AA);
      end else begin : g_word
         assign a_key1 = CW'(11'h555);
         assign a_key2 = CW'(11'h2AA);
         assign a_cfi  = CW'(11'h055);
      end
   endgenerate

   assign at_cmd   = (addr_lo == a_key1);
   assign at_cfi   = (addr_lo == a_cfi);
   assign hit_key1 = at_cmd && (data_lo == B_KEY1);
   assign hit_key2 = (addr_lo == a_key2) && (data_lo == B_KEY2);

endmodule

// File: rtl/fsc_op_tracker.sv
module fsc_op_tracker
   import flash_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     busy,
   input  logic     fire,
   input  op_kind_t kind,
   output eng_t     eng_state
);

   logic busy_q;
   logic busy_fell;

   assign busy_fell = busy_q && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         eng_state <= ENG_IDLE;
      end else begin
         busy_q <= busy;
         unique case (eng_state)
            ENG_IDLE: begin
               if (fire && kind == OPK_PROGRAM)           eng_state <= ENG_RUN_PGM;
               else if (fire && kind == OPK_CHIP_ERASE)   eng_state <= ENG_RUN_CE;
               else if (fire && kind == OPK_SECTOR_ERASE) eng_state <= ENG_RUN_SE;
            end
            ENG_RUN_PGM, ENG_RUN_CE: begin
               if (busy_fell) eng_state <= ENG_IDLE;
            end
            ENG_RUN_SE: begin
               if (fire && kind == OPK_SUSPEND) eng_state <= ENG_SUSP;
               else if (busy_fell)              eng_state <= ENG_IDLE;
            end
            ENG_SUSP: begin
               if (fire && kind == OPK_RESUME) eng_state <= ENG_RUN_SE;
            end
            default: eng_state <= ENG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fsc_seq_fsm.sv
module fsc_seq_fsm
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  eng_t              eng_state,
   input  logic              hit_key1,
   input  logic              hit_key2,
   input  logic              at_cmd,
   input  logic              at_cfi,
   output logic              fire_d,
   output op_kind_t          kind_d,
   output logic              op_valid,
   output op_kind_t          op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              bypass_mode,
   output logic              autosel_mode,
   output logic              cfi_mode
);

   seq_t       state, state_d;
   logic       byp_d, asel_d, cfi_d;
   logic [7:0] cb;
   logic       data_cycle;
   logic       start_ok;

   assign cb         = wr_data[7:0];
   assign data_cycle = (state == S_PGM_DATA) || (state == S_CFG_DATA) || (state == S_BYP_PGM);
   assign start_ok   = !busy && (eng_state == ENG_IDLE);

   always_comb begin
      state_d = state;
      fire_d  = 1'b0;
      kind_d  = OPK_NONE;
      byp_d   = bypass_mode;
      asel_d  = autosel_mode;
      cfi_d   = cfi_mode;
      if (wr_en) begin
         if (cb == B_RESET && !data_cycle) begin
            fire_d  = 1'b1;
            kind_d  = OPK_RESET;
            state_d = S_IDLE;
            asel_d  = 1'b0;
            cfi_d   = 1'b0;
         end else begin
            state_d = S_IDLE;
            unique case (state)
               S_IDLE: begin
                  if (cb == B_SUSPEND && eng_state == ENG_RUN_SE) begin
                     fire_d = 1'b1;
                     kind_d = OPK_SUSPEND;
                  end else if (cb == B_RESUME && eng_state == ENG_SUSP) begin
                     fire_d = 1'b1;
                     kind_d = OPK_RESUME;
                  end else if (bypass_mode) begin
                     if (cb == B_PROGRAM)      state_d = S_BYP_PGM;
                     else if (cb == B_ERASE)   state_d = S_BYP_ER;
                     else if (cb == B_AUTOSEL) state_d = S_BYP_EXIT;
                     else if (cb == B_CFI) begin
                        fire_d = 1'b1;
                        kind_d = OPK_CFI;
                        cfi_d  = 1'b1;
                     end
                  end else if (hit_key1) begin
                     state_d = S_UL1;
                  end else if (cb == B_CFI && at_cfi) begin
                     fire_d = 1'b1;
                     kind_d = OPK_CFI;
                     cfi_d  = 1'b1;
                  end
               end
               S_UL1: if (hit_key2) state_d = S_UL2;
               S_UL2: begin
                  if (at_cmd) begin
                     if (cb == B_PROGRAM)    state_d = S_PGM_DATA;
                     else if (cb == B_ERASE) state_d = S_ER_UL0;
                     else if (cb == B_BYPASS) byp_d  = 1'b1;
                     else if (cb == B_AUTOSEL) begin
                        fire_d = 1'b1;
                        kind_d = OPK_AUTOSEL;
                        asel_d = 1'b1;
                     end else if (cb == B_CFG && start_ok) state_d = S_CFG_DATA;
                  end
               end
               S_PGM_DATA, S_BYP_PGM: begin
                  if (start_ok) begin
                     fire_d = 1'b1;
                     kind_d = OPK_PROGRAM;
                  end
               end
               S_ER_UL0: if (hit_key1) state_d = S_ER_UL1;
               S_ER_UL1: if (hit_key2) state_d = S_ER_CMD;
               S_ER_CMD: begin
                  if (start_ok && cb == B_CHIP && at_cmd) begin
                     fire_d = 1'b1;
                     kind_d = OPK_CHIP_ERASE;
                  end else if (start_ok && cb == B_SECTOR) begin
                     fire_d = 1'b1;
                     kind_d = OPK_SECTOR_ERASE;
                  end
               end
               S_CFG_DATA: begin
                  if (start_ok) begin
                     fire_d = 1'b1;
                     kind_d = OPK_CFG_WRITE;
                  end
               end
               S_BYP_ER: begin
                  if (start_ok && cb == B_CHIP) begin
                     fire_d = 1'b1;
                     kind_d = OPK_CHIP_ERASE;
                  end
               end
               S_BYP_EXIT: if (cb == B_BYP_OUT) byp_d = 1'b0;
               default: state_d = S_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         op_valid     <= 1'b0;
         op_kind      <= OPK_NONE;
         op_addr      <= '0;
         op_data      <= '0;
         bypass_mode  <= 1'b0;
         autosel_mode <= 1'b0;
         cfi_mode     <= 1'b0;
      end else begin
         state        <= state_d;
         op_valid     <= fire_d;
         op_kind      <= kind_d;
         bypass_mode  <= byp_d;
         autosel_mode <= asel_d;
         cfi_mode     <= cfi_d;
         if (fire_d) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
         end
      end
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 32,
   parameter bit HALF_WORD = 1'b0,
   localparam int CW = cmp_width(HALF_WORD)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output logic              op_valid,
   output logic [3:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic              bypass_mode,
   output logic              autosel_mode,
   output logic              cfi_mode
);

   generate
      if (ADDR_W < CW) begin : g_bad_addr
         $error("ADDR_W must cover the compared address bits");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold a command byte");
      end
   endgenerate

   logic     hit_key1, hit_key2, at_cmd, at_cfi;
   logic     fire_d;
   op_kind_t kind_d, kind_q;
   eng_t     eng_state;

   fsc_cycle_match #(.HALF_WORD(HALF_WORD)) u_match (
      .addr_lo (wr_addr[CW-1:0]),
      .data_lo (wr_data[7:0]),
      .hit_key1(hit_key1),
      .hit_key2(hit_key2),
      .at_cmd  (at_cmd),
      .at_cfi  (at_cfi)
   );

   fsc_op_tracker u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .fire     (fire_d),
      .kind     (kind_d),
      .eng_state(eng_state)
   );

   fsc_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .busy        (busy),
      .eng_state   (eng_state),
      .hit_key1    (hit_key1),
      .hit_key2    (hit_key2),
      .at_cmd      (at_cmd),
      .at_cfi      (at_cfi),
      .fire_d      (fire_d),
      .kind_d      (kind_d),
      .op_valid    (op_valid),
      .op_kind     (kind_q),
      .op_addr     (op_addr),
      .op_data     (op_data),
      .bypass_mode (bypass_mode),
      .autosel_mode(autosel_mode),
      .cfi_mode    (cfi_mode)
   );

   assign op_kind = kind_q;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
   import flash_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_byte,
   input logic       busy,
   input logic       op_valid,
   input logic [3:0] op_kind,
   input logic       bypass_mode,
   input logic       autosel_mode,
   input logic       cfi_mode,
   input eng_t       eng_state
);

   // R2
   op_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> $past(wr_en));

   // R9
   start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_kind == 4'd1 || op_kind == 4'd2 || op_kind == 4'd3))
      |-> (!$past(busy) && $past(eng_state) == ENG_IDLE));

   // R6
   suspend_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 4'd4) |-> $past(eng_state) == ENG_RUN_SE);

   // R6
   resume_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 4'd5) |-> $past(eng_state) == ENG_SUSP);

   // R5
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 4'd8) |-> (!autosel_mode && !cfi_mode));

   // R7
   bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass_mode) |-> ($past(wr_en) && $past(wr_byte) == 8'h20));

   // R10
   cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 4'd9) |-> $past(eng_state) == ENG_IDLE);

   // R11
   suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eng_state) == ENG_SUSP && !(op_valid && op_kind == 4'd5))
      |-> eng_state == ENG_SUSP);

endmodule

bind flash_cmd_seq fsc_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_byte     (wr_data[7:0]),
   .busy        (busy),
   .op_valid    (op_valid),
   .op_kind     (op_kind),
   .bypass_mode (bypass_mode),
   .autosel_mode(autosel_mode),
   .cfi_mode    (cfi_mode),
   .eng_state   (eng_state)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        busy = 1'b0;
   logic        op_valid;
   logic [3:0]  op_kind;
   logic [18:0] op_addr;
   logic [31:0] op_data;
   logic        bypass_mode, autosel_mode, cfi_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        l_valid;
   logic [3:0]  l_kind;
   logic [18:0] l_addr;
   logic [31:0] l_data;

   always #5 clk = ~clk;

   flash_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
      .op_data(op_data), .bypass_mode(bypass_mode), .autosel_mode(autosel_mode),
      .cfi_mode(cfi_mode)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [18:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      l_valid = op_valid; l_kind = op_kind; l_addr = op_addr; l_data = op_data;
      wr_en = 1'b0;
   endtask

   task automatic expect_op(input string req, input logic [3:0] k, input logic [18:0] a, input logic [31:0] d);
      chk(req, "op_valid", 64'(l_valid), 64'd1);
      chk(req, "op_kind", 64'(l_kind), 64'(k));
      chk(req, "op_addr", 64'(l_addr), 64'(a));
      chk(req, "op_data", 64'(l_data), 64'(d));
   endtask

   task automatic expect_none(input string req);
      chk(req, "no op_valid", 64'(l_valid), 64'd0);
   endtask

   task automatic unlock();
      wr(19'h00555, 32'hAA);
      wr(19'h002AA, 32'h55);
   endtask

   task automatic finish_op();
      @(negedge clk); busy = 1'b1;
      repeat (3) @(negedge clk);
      busy = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk("R5", "op_valid after reset", 64'(op_valid), 64'd0);
      chk("R5", "bypass after reset", 64'(bypass_mode), 64'd0);
      chk("R5", "autosel after reset", 64'(autosel_mode), 64'd0);
      chk("R5", "cfi after reset", 64'(cfi_mode), 64'd0);
   endtask

   task automatic t_program();
      // R1: high address and data bits set during unlock and command
      wr(19'h7F555, 32'hFFFF_FFAA); expect_none("R1");
      wr(19'h3A2AA, 32'h1234_5655); expect_none("R1");
      wr(19'h40555, 32'hABCD_00A0); expect_none("R1");
      wr(19'h12345, 32'hDEAD_BEEF);
      expect_op("R2", 4'd1, 19'h12345, 32'hDEAD_BEEF);
      finish_op();
      // R2: data byte F0 is program data
      unlock();
      wr(19'h00555, 32'hA0);
      wr(19'h00100, 32'h0000_00F0);
      expect_op("R2", 4'd1, 19'h00100, 32'h0000_00F0);
      finish_op();
   endtask

   task automatic t_mismatch();
      wr(19'h00555, 32'hAA);
      wr(19'h002AB, 32'h55); expect_none("R4");
      wr(19'h00555, 32'hA0); expect_none("R4");
      wr(19'h00100, 32'h11); expect_none("R4");
      unlock();
      wr(19'h00555, 32'h77); expect_none("R4");
      wr(19'h00100, 32'h11); expect_none("R4");
      unlock();
      wr(19'h00554, 32'hA0);
      wr(19'h00100, 32'h11); expect_none("R4");
   endtask

   task automatic t_chip_erase();
      unlock();
      wr(19'h00555, 32'h80);
      unlock();
      wr(19'h00555, 32'h10);
      expect_op("R3", 4'd2, 19'h00555, 32'h10);
      finish_op();
   endtask

   task automatic t_sector_suspend();
      unlock();
      wr(19'h00555, 32'h80);
      unlock();
      wr(19'h48000, 32'h30);
      expect_op("R3", 4'd3, 19'h48000, 32'h30);
      @(negedge clk); busy = 1'b1;
      wr(19'h48000, 32'h30); expect_none("R6");
      wr(19'h40000, 32'hB0);
      expect_op("R9", 4'd4, 19'h40000, 32'hB0);
      @(negedge clk); busy = 1'b0;
      repeat (2) @(negedge clk);
      wr(19'h40000, 32'hB0); expect_none("R6");
      wr(19'h40000, 32'h30);
      expect_op("R6", 4'd5, 19'h40000, 32'h30);
      finish_op();
      wr(19'h40000, 32'hB0); expect_none("R11");
   endtask

   task automatic t_autosel_cfi();
      unlock();
      wr(19'h00555, 32'h90);
      expect_op("R8", 4'd6, 19'h00555, 32'h90);
      chk("R8", "autosel set", 64'(autosel_mode), 64'd1);
      wr(19'h7FFFF, 32'hF0);
      expect_op("R5", 4'd8, 19'h7FFFF, 32'hF0);
      chk("R5", "autosel cleared", 64'(autosel_mode), 64'd0);
      wr(19'h00055, 32'h98);
      expect_op("R8", 4'd7, 19'h00055, 32'h98);
      chk("R8", "cfi set", 64'(cfi_mode), 64'd1);
      wr(19'h00000, 32'hF0);
      chk("R5", "cfi cleared", 64'(cfi_mode), 64'd0);
      wr(19'h00056, 32'h98); expect_none("R8");
      chk("R8", "cfi stays clear", 64'(cfi_mode), 64'd0);
   endtask

   task automatic t_busy_block();
      @(negedge clk); busy = 1'b1;
      unlock();
      wr(19'h00555, 32'hA0);
      wr(19'h00200, 32'h33); expect_none("R9");
      unlock();
      wr(19'h00555, 32'h80);
      unlock();
      wr(19'h00555, 32'h10); expect_none("R9");
      wr(19'h00321, 32'hF0);
      expect_op("R9", 4'd8, 19'h00321, 32'hF0);
      @(negedge clk); busy = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_cfg();
      unlock();
      wr(19'h00555, 32'hD0);
      wr(19'h00010, 32'h0000_1234);
      expect_op("R10", 4'd9, 19'h00010, 32'h0000_1234);
      unlock();
      wr(19'h00555, 32'hA0);
      wr(19'h00400, 32'h44);
      expect_op("R2", 4'd1, 19'h00400, 32'h44);
      unlock();
      wr(19'h00555, 32'hD0);
      wr(19'h00010, 32'h0000_5678); expect_none("R10");
      unlock();
      wr(19'h00555, 32'hA0);
      wr(19'h00404, 32'h45); expect_none("R11");
      finish_op();
      unlock();
      wr(19'h00555, 32'hD0);
      wr(19'h00011, 32'h0000_9ABC);
      expect_op("R11", 4'd9, 19'h00011, 32'h0000_9ABC);
   endtask

   task automatic t_bypass();
      unlock();
      wr(19'h00555, 32'h20);
      chk("R7", "bypass set", 64'(bypass_mode), 64'd1);
      wr(19'h00000, 32'hA0); expect_none("R7");
      wr(19'h05000, 32'hCAFE_0001);
      expect_op("R7", 4'd1, 19'h05000, 32'hCAFE_0001);
      finish_op();
      wr(19'h00000, 32'h80);
      wr(19'h00000, 32'h10);
      expect_op("R7", 4'd2, 19'h00000, 32'h10);
      finish_op();
      wr(19'h00123, 32'h98);
      expect_op("R7", 4'd7, 19'h00123, 32'h98);
      wr(19'h00000, 32'hF0);
      chk("R5", "cfi cleared in bypass", 64'(cfi_mode), 64'd0);
      chk("R5", "bypass kept by reset", 64'(bypass_mode), 64'd1);
      wr(19'h00000, 32'h90);
      wr(19'h00000, 32'h00);
      chk("R7", "bypass cleared", 64'(bypass_mode), 64'd0);
      wr(19'h00555, 32'hA0);
      wr(19'h06000, 32'h11); expect_none("R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_program();
      t_mismatch();
      t_chip_erase();
      t_sector_suspend();
      t_autosel_cfi();
      t_busy_block();
      t_cfg();
      t_bypass();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule